// File: doc/BRIEF.md
# SEC-DED Word Protector with Nibble Detection

This block guards 32-bit memory words with 8 check bits, giving a 40-bit codeword. On the write side it turns the data word into check bits through a purely combinational encoder, so the memory controller can store them in the same cycle. On the read side it takes the stored data and check bits, forms the syndrome, repairs any single flipped bit, and reports it as correctable. Any double-bit error is reported as uncorrectable. So is any damage confined to one aligned 4-bit nibble of the codeword.

The parity-check column of each data bit has odd weight. Within every aligned nibble, one half of the syndrome carries a one-hot position code. Because of this, two, three or four flips inside one nibble can never look like a clean word or like a single flip. Read results leave through one register stage. The first failing access is recorded with its address, its syndrome and its kind. The record stays in place until a clear request arrives. Any later errors only raise a sticky overflow flag.

Top module: `ecc_nibble_guard`

## Requirements
- R1: Codeword bit i (0..31 data, 32..39 check bit i-32) has an 8-bit column. The column of check bit k is 1<<k. For data bit i, let n = i/4 and j = i%4, with P = {0011, 0101, 0110, 1001} indexed by n%4. For n<4 the column is {P[n], 1<<j}, and for n>=4 it is {1<<j, P[n-4]}, with the left half written as bits 7:4. wr_check bit k is the XOR of the data bits whose column has bit k set.
- R2: A read whose syndrome (rd_check XOR the check bits recomputed from rd_data) is zero returns rd_data unchanged on out_data with out_ce=0 and out_ue=0, one cycle after the clock edge that samples rd_valid.
- R3: A syndrome equal to the column of one data bit flips that bit on out_data and sets out_ce=1, out_ue=0.
- R4: A syndrome with exactly one bit set (a flipped check bit) returns rd_data unchanged with out_ce=1, out_ue=0.
- R5: Any other nonzero syndrome, including every double-bit error, sets out_ue=1, out_ce=0, and out_data equals the raw rd_data.
- R6: Any error of 2 to 4 bits inside one aligned nibble of the 40-bit codeword (bits 4m..4m+3, m=0..9) gives out_ue=1.
- R7: out_syndrome presents the syndrome of the registered read.
- R8: The first error (correctable or not) sets log_valid and captures rd_addr, the syndrome and log_ue (1 for uncorrectable) in the same register stage as the read result.
- R9: While log_valid is set and no clear is requested, a further error leaves the logged address, syndrome and kind unchanged and sets log_overflow, which stays set.
- R10: log_clear empties the log and drops log_overflow. An error in the same cycle is then logged as a new first error.
- R11: While rst is high all registered outputs go to zero.
- R12: With rd_valid low, out_valid, out_ce and out_ue are 0 and the log does not change, whatever rd_data and rd_check carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 32 | Data word to be stored |
| wr_check | output | 8 | Check bits for wr_data (combinational) |
| rd_valid | input | 1 | A read word is present this cycle |
| rd_addr | input | ADDR_W | Address of the read access |
| rd_data | input | 32 | Data bits as read from memory |
| rd_check | input | 8 | Check bits as read from memory |
| log_clear | input | 1 | Empties the error log |
| out_valid | output | 1 | Registered read result is present |
| out_data | output | 32 | Corrected (or raw, if uncorrectable) data |
| out_ce | output | 1 | Single-bit error was corrected |
| out_ue | output | 1 | Uncorrectable error detected |
| out_syndrome | output | 8 | Syndrome of the registered read |
| log_valid | output | 1 | An error is held in the log |
| log_ue | output | 1 | Logged error was uncorrectable |
| log_addr | output | ADDR_W | Address of the first logged error |
| log_syndrome | output | 8 | Syndrome of the first logged error |
| log_overflow | output | 1 | A further error arrived while the log was full |

## Verification
The hardest cases to reach from the ports are multi-bit patterns that stay inside one nibble, above all inside the two check-bit nibbles, and a clear that lands in the same cycle as a new error. The stimulus first takes genuine check bits from the block's own write path. It then XORs a 40-bit error mask onto the whole codeword, so every nibble, including the check nibbles, can be hit with two, three or four flips. Directed steps then line up log_clear with a failing read on the same edge, and present corrupted words with rd_valid low.

// File: rtl/ecc_ng_pkg.sv
package ecc_ng_pkg;

    localparam int DATA_W   = 32;
    localparam int CHK_W    = 8;
    localparam int CW_W     = DATA_W + CHK_W;
    localparam int NIB_W    = 4;
    localparam int HALF_W   = CHK_W / 2;
    localparam int DATA_NIB = DATA_W / NIB_W;
    localparam int LOW_NIB  = DATA_NIB / 2;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CHK_W-1:0]  chk_t;

    typedef enum logic [1:0] {
        DEC_CLEAN     = 2'd0,
        DEC_FIX_DATA  = 2'd1,
        DEC_FIX_CHECK = 2'd2,
        DEC_FATAL     = 2'd3
    } dec_kind_t;

    typedef struct packed {
        data_t     data;
        chk_t      syn;
        dec_kind_t kind;
    } dec_res_t;

    // Even-weight tag of a nibble group; four distinct weight-2 values.
    function automatic logic [HALF_W-1:0] nib_tag(input int n);
        logic [HALF_W-1:0] t;
        case (n % 4)
            0:       t = 4'b0011;
            1:       t = 4'b0101;
            2:       t = 4'b0110;
            default: t = 4'b1001;
        endcase
        return t;
    endfunction

    // Parity-check column of codeword bit i.
    function automatic chk_t col_of(input int i);
        chk_t c;
        int   n;
        int   j;
        logic [HALF_W-1:0] pos;
        if (i >= DATA_W) begin
            c = chk_t'(1) << (i - DATA_W);
        end else begin
            n   = i / NIB_W;
            j   = i % NIB_W;
            pos = HALF_W'(1) << j;
            if (n < LOW_NIB) c = {nib_tag(n), pos};
            else             c = {pos, nib_tag(n - LOW_NIB)};
        end
        return c;
    endfunction

    // Data bits that feed check bit k.
    function automatic data_t row_mask(input int k);
        data_t m;
        chk_t  c;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            c    = col_of(i);
            m[i] = c[k];
        end
        return m;
    endfunction

    function automatic logic is_single(input chk_t s);
        return (s != '0) && ((s & (s - chk_t'(1))) == '0);
    endfunction

endpackage

// File: rtl/ecc_ng_encoder.sv
module ecc_ng_encoder
    import ecc_ng_pkg::*;
(
    input  data_t data,
    output chk_t  check
);

    for (genvar k = 0; k < CHK_W; k++) begin : g_row
        localparam data_t MASK = row_mask(k);
        assign check[k] = ^(data & MASK);
    end

endmodule

// File: rtl/ecc_ng_decoder.sv
module ecc_ng_decoder
    import ecc_ng_pkg::*;
(
    input  data_t    raw_data,
    input  chk_t     raw_check,
    output dec_res_t res
);

    chk_t  recomputed;
    chk_t  syn;
    data_t hit;
    logic  chk_hit;

    ecc_ng_encoder u_reenc (
        .data  (raw_data),
        .check (recomputed)
    );

    assign syn = raw_check ^ recomputed;

    for (genvar i = 0; i < DATA_W; i++) begin : g_match
        localparam chk_t COL = col_of(i);
        assign hit[i] = (syn == COL);
    end

    assign chk_hit = is_single(syn);

    always_comb begin
        res.syn  = syn;
        res.data = raw_data;
        if (syn == '0) begin
            res.kind = DEC_CLEAN;
        end else if (hit != '0) begin
            res.kind = DEC_FIX_DATA;
            res.data = raw_data ^ hit;
        end else if (chk_hit) begin
            res.kind = DEC_FIX_CHECK;
        end else begin
            res.kind = DEC_FATAL;
        end
    end

endmodule

// File: rtl/ecc_ng_errlog.sv
module ecc_ng_errlog
    import ecc_ng_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              err_in,
    input  logic              err_ue,
    input  logic [ADDR_W-1:0] err_addr,
    input  chk_t              err_syn,
    output logic              log_valid,
    output logic              log_ue,
    output logic [ADDR_W-1:0] log_addr,
    output chk_t              log_syn,
    output logic              log_ovf
);

    logic capture;

    assign capture = err_in && (clear || !log_valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            log_valid <= 1'b0;
            log_ue    <= 1'b0;
            log_addr  <= '0;
            log_syn   <= '0;
            log_ovf   <= 1'b0;
        end else begin
            if (clear) begin
                log_valid <= err_in;
                log_ovf   <= 1'b0;
            end else if (err_in) begin
                log_valid <= 1'b1;
                if (log_valid) log_ovf <= 1'b1;
            end
            if (capture) begin
                log_ue   <= err_ue;
                log_addr <= err_addr;
                log_syn  <= err_syn;
            end else if (clear) begin
                log_ue   <= 1'b0;
                log_addr <= '0;
                log_syn  <= '0;
            end
        end
    end

    // R9
    log_hold_chk: assert property (@(posedge clk) disable iff (rst)
        log_valid && !clear |=> log_valid && $stable(log_addr) && $stable(log_syn) && $stable(log_ue));

    // R9
    ovf_needs_log_chk: assert property (@(posedge clk) disable iff (rst)
        log_ovf |-> log_valid);

    // R10
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clear && !err_in |=> !log_valid && !log_ovf);

    // R8
    first_capture_chk: assert property (@(posedge clk) disable iff (rst)
        !log_valid && err_in |=> log_valid && log_addr == $past(err_addr));

endmodule

// File: rtl/ecc_nibble_guard.sv
module ecc_nibble_guard
    import ecc_ng_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       wr_data,
    output logic [7:0]        wr_check,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [31:0]       rd_data,
    input  logic [7:0]        rd_check,
    input  logic              log_clear,
    output logic              out_valid,
    output logic [31:0]       out_data,
    output logic              out_ce,
    output logic              out_ue,
    output logic [7:0]        out_syndrome,
    output logic              log_valid,
    output logic              log_ue,
    output logic [ADDR_W-1:0] log_addr,
    output logic [7:0]        log_syndrome,
    output logic              log_overflow
);

    dec_res_t dec;
    logic     dec_ce;
    logic     dec_ue;

    ecc_ng_encoder u_wr_enc (
        .data  (wr_data),
        .check (wr_check)
    );

    ecc_ng_decoder u_dec (
        .raw_data  (rd_data),
        .raw_check (rd_check),
        .res       (dec)
    );

    assign dec_ce = (dec.kind == DEC_FIX_DATA) || (dec.kind == DEC_FIX_CHECK);
    assign dec_ue = (dec.kind == DEC_FATAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_data     <= '0;
            out_ce       <= 1'b0;
            out_ue       <= 1'b0;
            out_syndrome <= '0;
        end else begin
            out_valid    <= rd_valid;
            out_data     <= rd_valid ? dec.data : '0;
            out_ce       <= rd_valid && dec_ce;
            out_ue       <= rd_valid && dec_ue;
            out_syndrome <= rd_valid ? dec.syn : '0;
        end
    end

    ecc_ng_errlog #(.ADDR_W(ADDR_W)) u_log (
        .clk       (clk),
        .rst       (rst),
        .clear     (log_clear),
        .err_in    (rd_valid && (dec_ce || dec_ue)),
        .err_ue    (dec_ue),
        .err_addr  (rd_addr),
        .err_syn   (dec.syn),
        .log_valid (log_valid),
        .log_ue    (log_ue),
        .log_addr  (log_addr),
        .log_syn   (log_syndrome),
        .log_ovf   (log_overflow)
    );

    // R2
    clean_pass_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_syndrome == '0 |-> out_data == $past(rd_data) && !out_ce && !out_ue);

    // R3
    single_flip_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ce |-> $countones(out_data ^ $past(rd_data)) <= 1);

    // R5
    raw_on_fatal_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ue |-> out_data == $past(rd_data) && !out_ce);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_ce && !out_ue);

endmodule

// File: tb/ecc_nibble_guard_tb.sv
module ecc_nibble_guard_tb;

    localparam int ADDR_W = 32;
    localparam int NV     = 16;
    // {kind[1:0], mask[39:0], data[31:0]}; kind 0 clean, 1 correctable, 2 fatal
    localparam logic [73:0] VEC [NV] = '{
        {2'd0, 40'h00_0000_0000, 32'hDEAD_BEEF},
        {2'd0, 40'h00_0000_0000, 32'h0000_0000},
        {2'd0, 40'h00_0000_0000, 32'hFFFF_FFFF},
        {2'd1, 40'h00_0000_0001, 32'h1234_5678},
        {2'd1, 40'h00_8000_0000, 32'hA5A5_A5A5},
        {2'd1, 40'h01_0000_0000, 32'h0F0F_00FF},
        {2'd1, 40'h80_0000_0000, 32'h8000_0001},
        {2'd1, 40'h00_0002_0000, 32'h5555_AAAA},
        {2'd2, 40'h00_0010_0001, 32'hCAFE_F00D},
        {2'd2, 40'h02_0000_0020, 32'h1357_9BDF},
        {2'd2, 40'h00_0000_0700, 32'h2468_ACE0},
        {2'd2, 40'h00_F000_0000, 32'h7777_1111},
        {2'd2, 40'h07_0000_0000, 32'h0BAD_CAFE},
        {2'd2, 40'hF0_0000_0000, 32'hFEED_FACE},
        {2'd2, 40'h00_0070_0000, 32'h3C3C_C3C3},
        {2'd2, 40'h00_0000_0009, 32'h9999_6666}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [31:0]       wr_data = '0;
    logic [7:0]        wr_check;
    logic              rd_valid = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0]       rd_data = '0;
    logic [7:0]        rd_check = '0;
    logic              log_clear = 1'b0;
    logic              out_valid;
    logic [31:0]       out_data;
    logic              out_ce;
    logic              out_ue;
    logic [7:0]        out_syndrome;
    logic              log_valid;
    logic              log_ue;
    logic [ADDR_W-1:0] log_addr;
    logic [7:0]        log_syndrome;
    logic              log_overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ecc_nibble_guard #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_check(wr_check),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .rd_check(rd_check),
        .log_clear(log_clear), .out_valid(out_valid), .out_data(out_data),
        .out_ce(out_ce), .out_ue(out_ue), .out_syndrome(out_syndrome),
        .log_valid(log_valid), .log_ue(log_ue), .log_addr(log_addr),
        .log_syndrome(log_syndrome), .log_overflow(log_overflow)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Column model taken from the R1 rule.
    function automatic logic [7:0] spec_col(input int i);
        logic [3:0] tag;
        int n;
        if (i >= 32) return 8'(1) << (i - 32);
        n = i / 4;
        case (n % 4)
            0: tag = 4'b0011;
            1: tag = 4'b0101;
            2: tag = 4'b0110;
            default: tag = 4'b1001;
        endcase
        if (n < 4) return {tag, 4'(1) << (i % 4)};
        return {4'(1) << (i % 4), tag};
    endfunction

    function automatic logic [7:0] spec_syn(input logic [39:0] cw_mask);
        logic [7:0] s = '0;
        for (int i = 0; i < 40; i++) if (cw_mask[i]) s ^= spec_col(i);
        return s;
    endfunction

    function automatic logic [7:0] spec_enc(input logic [31:0] d);
        return spec_syn({8'h00, d});
    endfunction

    function automatic bit in_one_nibble(input logic [39:0] m);
        for (int g = 0; g < 10; g++)
            if ((m & ~(40'hF << (4 * g))) == '0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic read_word(input logic [31:0] d, input logic [7:0] c,
                             input logic [ADDR_W-1:0] a, input logic v, input logic clr);
        @(negedge clk);
        rd_valid  = v;
        rd_data   = d;
        rd_check  = c;
        rd_addr   = a;
        log_clear = clr;
        @(posedge clk);
        #1;
        rd_valid  = 1'b0;
        log_clear = 1'b0;
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int first_err;
        logic [31:0] enc_chk;
        logic [31:0] good_d;
        logic [7:0]  good_c;
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        check("R11", {out_valid, out_ce, out_ue, log_valid, log_ue, log_overflow},
              64'd0);
        check("R11", {out_data, out_syndrome, log_syndrome}, 64'd0);
        check("R11", 64'(log_addr), 64'd0);
        @(negedge clk);
        rst = 1'b0;

        first_err = -1;
        for (int v = 0; v < NV; v++) begin
            logic [31:0] d;
            logic [39:0] m;
            logic [1:0]  k;
            logic [39:0] cw;
            logic [7:0]  es;
            logic [31:0] ed;
            string       req;
            d = VEC[v][31:0];
            m = VEC[v][71:32];
            k = VEC[v][73:72];
            @(negedge clk);
            wr_data = d;
            #1;
            // R1 encoder against column rule
            check("R1", 64'(wr_check), 64'(spec_enc(d)));
            cw = {wr_check, d} ^ m;
            es = spec_syn(m);
            if (k == 2'd0)       req = "R2";
            else if (k == 2'd1)  req = (m[39:32] != 0) ? "R4" : "R3";
            else                 req = in_one_nibble(m) ? "R6" : "R5";
            if (k != 2'd0 && first_err < 0) first_err = v;
            read_word(cw[31:0], cw[39:32], 32'h1000 + 32'(v) * 4, 1'b1, 1'b0);
            ed = (k == 2'd2) ? cw[31:0] : d;
            check(req, {32'(out_valid), out_data}, {32'd1, ed});
            check(req, {62'd0, out_ce, out_ue}, {62'd0, k == 2'd1, k == 2'd2});
            // R7 syndrome reported
            check("R7", 64'(out_syndrome), 64'(es));
        end

        // R8 first error logged; R9 overflow after later errors
        check("R8", {32'(log_valid), log_addr}, {32'd1, 32'h1000 + 32'(first_err) * 4});
        check("R8", {55'd0, log_ue, log_syndrome},
              {55'd0, 1'b0, spec_syn(VEC[first_err][71:32])});
        check("R9", 64'(log_overflow), 64'd1);

        good_d = 32'h0BEE_F123;
        @(negedge clk);
        wr_data = good_d;
        #1;
        good_c = wr_check;
        enc_chk = 32'(good_c);
        check("R1", 64'(enc_chk), 64'(spec_enc(good_d)));

        // R12 corrupted word with rd_valid low
        read_word(good_d ^ 32'h3, good_c, 32'hDEAD_0000, 1'b0, 1'b0);
        check("R12", {61'd0, out_valid, out_ce, out_ue}, 64'd0);
        check("R12", {32'(log_valid), log_addr}, {32'd1, 32'h1000 + 32'(first_err) * 4});

        // R10 clear alone
        read_word(good_d, good_c, 32'h0, 1'b0, 1'b1);
        check("R10", {62'd0, log_valid, log_overflow}, 64'd0);
        check("R10", 64'(log_addr), 64'd0);

        // R10 clear together with a new fatal error
        read_word(good_d ^ 32'h0000_0300, good_c, 32'h0000_ABC0, 1'b1, 1'b1);
        check("R10", {32'(log_valid), log_addr}, {32'd1, 32'h0000_ABC0});
        check("R10", {55'd0, log_ue, log_syndrome},
              {55'd0, 1'b1, spec_syn(40'h00_0000_0300)});
        check("R10", 64'(log_overflow), 64'd0);

        // R9 later correctable error keeps first record
        read_word(good_d ^ 32'h0001_0000, good_c, 32'h0000_0F00, 1'b1, 1'b0);
        check("R9", {32'(log_valid), log_addr}, {32'd1, 32'h0000_ABC0});
        check("R9", {55'd0, log_ue, log_overflow, 7'd0}, {55'd0, 1'b1, 1'b1, 7'd0});
        check("R3", 64'(out_data), 64'(good_d));

        // R2 clean read leaves log untouched
        read_word(good_d, good_c, 32'h0000_1111, 1'b1, 1'b0);
        check("R2", {30'd0, out_ce, out_ue, out_data}, {32'd0, good_d});
        check("R9", 64'(log_addr), 64'h0000_ABC0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule